// File: doc/BRIEF.md
# Step-Adaptive Averaging Output Selector

This block sits behind a first-stage decimation filter and decides what the second filter stage hands downstream for each new sample. In steady operation it forwards the result of an FIR path, which arrives as an input alongside the raw first-stage sample. When the adaptive mode is enabled, it watches for a large jump between a sample and the sample two positions before it, or for a channel switch. On either event it swaps the FIR result for a short moving average, so a new level appears after one or two outputs instead of after the full FIR settling time.

Once the input stops jumping, the averaging window widens in fixed stages. Each stage trades the early answer for lower noise. After the last stage the block hands control back to the FIR path. A status flag shows whether the output currently comes from the averaging path, so a controller running single conversions knows to keep converting until the flag clears.

Top module: `step_settle_ctl`

## Requirements
- R1: With `cfg_fast` = 0, every result equals the `fir_data` presented with its strobe, and `settling` is 0, whatever the sample values.
- R2: With `cfg_skip` = 1, the result is the FIR value and `settling` is 0 even when `cfg_fast` = 1.
- R3: With `cfg_fast` = 1 and `cfg_skip` = 0, a sample whose absolute difference from the sample two strobes earlier is strictly greater than the threshold (full scale 2^24 divided by 100, truncated: 167772) selects the averaging path and sets `settling` to 1. A difference exactly equal to the threshold is not a step.
- R4: A `chan_chg` pulse, given in the same cycle as a strobe or in any cycle since the previous strobe, makes the next sample act as a step even if its value is unchanged.
- R5: On a step sample, the window length is 2 when `cfg_chop` = 1 and 1 when `cfg_chop` = 0. It stays at that length for every sample that is still a step.
- R6: An average over length L is the current sample plus the L-1 most recent earlier samples. The sum has L/2 added and is shifted right arithmetically by log2(L). The earlier samples include every strobe in any mode, and they are zero after reset.
- R7: After the first non-step sample, the window lengths run 2 for two outputs, then 4 for four, then 8 for eight, then 16 for six. The next non-step sample outputs the FIR value with `settling` back to 0.
- R8: A step during any stage of that schedule restarts it at the initial length.
- R9: `settling` stays 1 on every result from the step until the hand-back, so every strobe in that window yields an averaged result.
- R10: `res_vld` rises exactly one clock after each `smp_vld` and is low otherwise. `res_data` and `settling` change only with a result.
- R11: After reset, `res_vld`, `res_data` and `settling` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | First-stage sample strobe |
| smp_data | input | 24 | Signed first-stage sample |
| fir_data | input | 24 | FIR path result for the same sample |
| cfg_fast | input | 1 | Enables adaptive averaging |
| cfg_skip | input | 1 | Bypass mode; disables adaptive averaging |
| cfg_chop | input | 1 | Selects initial window length 2 (1) or 1 (0) |
| chan_chg | input | 1 | Channel-change pulse |
| res_vld | output | 1 | Result strobe |
| res_data | output | 24 | Selected result |
| settling | output | 1 | 1 while the averaging path drives the result |

## Verification
The main function is tried with a long steady level followed by one large jump, which shows the full 2/4/8/16 schedule and the hand-back. Jumps exactly at and one count above the threshold separate strict from non-strict comparison. Repeated jumps, both mid-schedule and back to back, show the restart and the held initial length. Channel changes with unchanged values, pulsed apart from and together with a strobe, show that the switch does not depend on the data. A long random run with mixed noise, jumps, channel pulses and configuration changes then checks the rounding of negative averages and the history kept across mode changes.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Window exponent for a given position within the settling schedule.
  function automatic int stage_log2(input int pos, input int n2, input int n4, input int n8);
    if (pos < n2)           return 1;
    if (pos < n2 + n4)      return 2;
    if (pos < n2 + n4 + n8) return 3;
    return 4;
  endfunction

  // Round-to-nearest division by 2**sh using an arithmetic shift.
  function automatic logic signed [63:0] round_shift(input logic signed [63:0] sum, input int sh);
    logic signed [63:0] half;
    if (sh == 0) return sum;
    half = 64'sd1 <<< (sh - 1);
    return (sum + half) >>> sh;
  endfunction

endpackage

// File: rtl/ssc_window.sv
module ssc_window #(
  parameter int DW    = 24,
  parameter int DEPTH = 16,
  parameter int LW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [DW-1:0] cur,
  input  logic [LW-1:0]        len_log2,
  output logic signed [DW-1:0] avg,
  output logic signed [DW-1:0] prev2
);
  import ssc_pkg::*;

  logic signed [DW-1:0] hist [DEPTH];
  logic signed [63:0]   sum;
  logic signed [63:0]   rounded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (push) begin
      hist[0] <= cur;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    sum = 64'(cur);
    for (int i = 0; i < DEPTH - 1; i++) begin
      if ((i + 1) < (1 << len_log2)) sum = sum + 64'(hist[i]);
    end
    rounded = round_shift(sum, int'(len_log2));
    avg     = rounded[DW-1:0];
  end

  assign prev2 = hist[1];

endmodule

// File: rtl/ssc_step_det.sv
module ssc_step_det #(
  parameter int    DW  = 24,
  parameter longint THR = 167772
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] prev2,
  input  logic                 chan_chg,
  output logic                 step_hit
);
  localparam logic [DW:0] THR_V = THR[DW:0];

  logic              chg_pend;
  logic signed [DW:0] diff;
  logic [DW:0]        mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chg_pend <= 1'b0;
    else if (smp_vld)  chg_pend <= 1'b0;
    else if (chan_chg) chg_pend <= 1'b1;
  end

  always_comb begin
    diff = (DW+1)'(cur) - (DW+1)'(prev2);
    mag  = diff[DW] ? (DW+1)'(-diff) : (DW+1)'(diff);
  end

  assign step_hit = chg_pend | chan_chg | (mag > THR_V);

endmodule

// File: rtl/ssc_sched.sv
module ssc_sched #(
  parameter int N2  = 2,
  parameter int N4  = 4,
  parameter int N8  = 8,
  parameter int N16 = 6,
  parameter int LW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          adapt,
  input  logic          chop,
  input  logic          step_hit,
  output logic          use_avg,
  output logic [LW-1:0] len_log2,
  output logic          active_nx,
  output logic          revert
);
  import ssc_pkg::*;

  localparam int TOTAL = N2 + N4 + N8 + N16;
  localparam int PW    = $clog2(TOTAL + 1);

  logic          active;
  logic [PW-1:0] pos, pos_nx;

  always_comb begin
    active_nx = active;
    pos_nx    = pos;
    use_avg   = 1'b0;
    len_log2  = '0;
    revert    = 1'b0;
    if (!adapt) begin
      active_nx = 1'b0;
    end else if (step_hit) begin
      active_nx = 1'b1;
      pos_nx    = '0;
      use_avg   = 1'b1;
      len_log2  = chop ? LW'(1) : LW'(0);
    end else if (active) begin
      if (pos == PW'(TOTAL)) begin
        active_nx = 1'b0;
        revert    = 1'b1;
      end else begin
        use_avg  = 1'b1;
        len_log2 = LW'(stage_log2(int'(pos), N2, N4, N8));
        pos_nx   = pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (smp_vld) begin
      active <= active_nx;
      pos    <= pos_nx;
    end
  end

endmodule

// File: rtl/step_settle_ctl.sv
module step_settle_ctl #(
  parameter int     DW         = 24,
  parameter int     DEPTH      = 16,
  parameter longint FULL_SCALE = 64'd16777216,
  parameter int     N2         = 2,
  parameter int     N4         = 4,
  parameter int     N8         = 8,
  parameter int     N16        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-1:0] fir_data,
  input  logic          cfg_fast,
  input  logic          cfg_skip,
  input  logic          cfg_chop,
  input  logic          chan_chg,
  output logic          res_vld,
  output logic [DW-1:0] res_data,
  output logic          settling
);
  localparam longint THR = FULL_SCALE / 100;
  localparam int     LW  = $clog2($clog2(DEPTH) + 1);

  logic                 adapt;
  logic                 step_hit;
  logic                 use_avg;
  logic                 active_nx;
  logic                 revert;
  logic [LW-1:0]        len_log2;
  logic signed [DW-1:0] avg;
  logic signed [DW-1:0] prev2;

  assign adapt = cfg_fast & ~cfg_skip;

  ssc_window #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_win (
    .clk(clk), .rst_n(rst_n), .push(smp_vld), .cur(smp_data),
    .len_log2(len_log2), .avg(avg), .prev2(prev2)
  );

  ssc_step_det #(.DW(DW), .THR(THR)) u_det (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cur(smp_data),
    .prev2(prev2), .chan_chg(chan_chg), .step_hit(step_hit)
  );

  ssc_sched #(.N2(N2), .N4(N4), .N8(N8), .N16(N16), .LW(LW)) u_sch (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .adapt(adapt),
    .chop(cfg_chop), .step_hit(step_hit), .use_avg(use_avg),
    .len_log2(len_log2), .active_nx(active_nx), .revert(revert)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_data <= '0;
      settling <= 1'b0;
    end else begin
      res_vld <= smp_vld;
      if (smp_vld) begin
        res_data <= use_avg ? avg : fir_data;
        settling <= active_nx;
      end
    end
  end

endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [DW-1:0] smp_data,
  input logic [DW-1:0] fir_data,
  input logic          cfg_fast,
  input logic          cfg_skip,
  input logic          cfg_chop,
  input logic          chan_chg,
  input logic          res_vld,
  input logic [DW-1:0] res_data,
  input logic          settling,
  input logic          step_hit,
  input logic          revert
);
  // R10
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> res_vld);
  // R10
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!res_vld && $stable(res_data) && $stable(settling)));
  // R1
  fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !cfg_fast) |=> (res_data == $past(fir_data) && !settling));
  // R2
  skip_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_skip) |=> (res_data == $past(fir_data) && !settling));
  // R3
  step_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_fast && !cfg_skip && step_hit) |=> settling);
  // R4
  chan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_fast && !cfg_skip && chan_chg) |=> settling);
  // R5
  len_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg_fast && !cfg_skip && step_hit && !cfg_chop) |=> (res_data == $past(smp_data)));
  // R7
  handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && revert) |=> (!settling && res_data == $past(fir_data)));
  // R9
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settling) |-> res_vld);
endmodule

bind step_settle_ctl ssc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
  .fir_data(fir_data), .cfg_fast(cfg_fast), .cfg_skip(cfg_skip),
  .cfg_chop(cfg_chop), .chan_chg(chan_chg), .res_vld(res_vld),
  .res_data(res_data), .settling(settling), .step_hit(step_hit),
  .revert(revert)
);

// File: tb/test_step_settle_ctl.sv
`timescale 1ns/1ps
module test_step_settle_ctl;
  localparam longint FS  = 64'd16777216;
  localparam longint THR = FS / 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [23:0] smp_data = '0;
  logic [23:0] fir_data = '0;
  logic        cfg_fast = 1'b0;
  logic        cfg_skip = 1'b0;
  logic        cfg_chop = 1'b0;
  logic        chan_chg = 1'b0;
  logic        res_vld;
  logic [23:0] res_data;
  logic        settling;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  longint mh [16];
  bit     m_act = 0;
  int     m_pos = 0;
  bit     m_pend = 0;
  string  tag = "R11";

  always #2.5 clk = ~clk;

  step_settle_ctl i_step_settle_ctl (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .fir_data(fir_data), .cfg_fast(cfg_fast), .cfg_skip(cfg_skip),
    .cfg_chop(cfg_chop), .chan_chg(chan_chg), .res_vld(res_vld),
    .res_data(res_data), .settling(settling)
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Expected window length (as a count) for a schedule position.
  function automatic longint sched_len(input int pos);
    int dwell [4] = '{2, 4, 8, 6};
    int acc = 0;
    for (int k = 0; k < 4; k++) begin
      acc += dwell[k];
      if (pos < acc) return longint'(2) << k;
    end
    return 0;
  endfunction

  function automatic longint floor_div(input longint num, input longint den);
    longint q = num / den;
    if (num < 0 && (num % den) != 0) q = q - 1;
    return q;
  endfunction

  task automatic chan_pulse();
    @(negedge clk) chan_chg = 1'b1;
    @(negedge clk) chan_chg = 1'b0;
    m_pend = 1;
  endtask

  task automatic push(input longint s, input longint f, input bit chg);
    longint d, L, sum, exp_d;
    bit adapt, step, exp_s;
    L = 0;
    adapt = cfg_fast && !cfg_skip;
    d = s - mh[1];
    if (d < 0) d = -d;
    step = m_pend || chg || (d > THR);
    if (!adapt) m_act = 0;
    else if (step) begin
      m_act = 1; m_pos = 0; L = cfg_chop ? 2 : 1;
    end else if (m_act) begin
      L = sched_len(m_pos);
      if (L == 0) m_act = 0;
      else m_pos++;
    end
    if (L == 0) exp_d = f;
    else begin
      sum = s;
      for (int i = 0; i < L - 1; i++) sum += mh[i];
      exp_d = floor_div(sum + L / 2, L);
    end
    exp_s = m_act;
    m_pend = 0;
    for (int i = 15; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = s;
    @(negedge clk);
    chk("R10", "idle res_vld", longint'(res_vld), 0);
    smp_vld = 1'b1; smp_data = s[23:0]; fir_data = f[23:0]; chan_chg = chg;
    @(negedge clk);
    smp_vld = 1'b0; chan_chg = 1'b0;
    chk("R10", "res_vld", longint'(res_vld), 1);
    chk(tag, "res_data", longint'($signed(res_data)), exp_d);
    chk(tag, "settling", longint'(settling), longint'(exp_s));
  endtask

  task automatic quiet(input longint base, input int n);
    for (int i = 0; i < n; i++) push(base + (i % 3) - 1, 1000 + i, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd40417));
    for (int i = 0; i < 16; i++) mh[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "res_vld", longint'(res_vld), 0);
    chk("R11", "res_data", longint'(res_data), 0);
    chk("R11", "settling", longint'(settling), 0);
    rst_n = 1'b1;

    // R1: adaptive mode off, large steps still give FIR
    tag = "R1"; cfg_fast = 0; cfg_chop = 1;
    push(0, 11, 0); push(5000000, 12, 0); push(-5000000, -13, 0); push(7, 14, 0);

    // R2: bypass overrides adaptive enable
    tag = "R2"; cfg_fast = 1; cfg_skip = 1;
    push(6000000, 21, 0); push(-6000000, 22, 0); push(3, 23, 1);

    // R3/R6/R7/R9: step then full schedule and hand-back
    tag = "R7"; cfg_skip = 0;
    quiet(1000, 30);
    tag = "R3"; push(4000000, 55, 0);
    tag = "R7"; quiet(4000000, 24);

    // R3 threshold boundary: equal is not a step, one above is
    tag = "R3";
    push(2000, 1, 0); push(2000, 2, 0);
    quiet(2000, 22);
    push(2000, 3, 0); push(2000, 4, 0);
    push(2000 + THR, 5, 0); push(2000 + THR, 6, 0);
    push(2000 + 2 * THR + 1, 7, 0);
    tag = "R6"; quiet(2000 + 2 * THR + 1, 22);

    // R8: restart mid-schedule
    tag = "R8";
    push(-3000000, 8, 0); quiet(-3000000, 9);
    push(3000000, 9, 0); quiet(3000000, 25);

    // R4: channel change with an unchanged value
    tag = "R4";
    chan_pulse(); push(3000000, 31, 0); quiet(3000000, 22);
    push(3000000, 32, 1); quiet(3000000, 22);

    // R5: initial length 1 held while steps continue
    tag = "R5"; cfg_chop = 0;
    push(-4000000, 41, 0); push(4000000, 42, 0); push(-4000000, 43, 0); push(4000000, 44, 0);
    tag = "R6"; quiet(-1234567, 24);

    // Random phase
    tag = "R6";
    begin
      longint level = 0;
      for (int n = 0; n < 600; n++) begin
        if (n % 50 == 0) begin
          @(negedge clk);
          cfg_fast = ($urandom_range(0, 3) != 0);
          cfg_skip = ($urandom_range(0, 5) == 0);
          cfg_chop = $urandom_range(0, 1);
        end
        if ($urandom_range(0, 11) == 0) level = longint'($urandom_range(0, 12000000)) - 6000000;
        if ($urandom_range(0, 29) == 0) chan_pulse();
        push(level + longint'($urandom_range(0, 600000)) - 300000 * ($urandom_range(0, 9) == 0)
             - longint'($urandom_range(0, 2000)),
             longint'($urandom_range(0, 16000000)) - 8000000,
             $urandom_range(0, 39) == 0);
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule